// File: doc/BRIEF.md
# T1 Line Performance Error Counter Bank

This block keeps the line-quality statistics of a T1 receiver in a small bank of saturating counters. A 16-bit counter totals line-code violations plus excessive-zero events. An 8-bit counter totals CRC-6 word errors. A second 8-bit counter totals out-of-frame events. The line decoder and framer feed it single-cycle strobes. The block also watches the decoded bit stream itself, looking for long runs of zeros. The run length that counts as excessive is 8 zeros when B8ZS substitution is on and 16 zeros when it is off.

Software presets and reads the counts through a byte-wide port with four addresses. The 16-bit counter is preset in two steps. A write to the high-byte address only stages the byte. The next write to the low-byte address loads the staged byte and the new low byte together.

Each counter stops at its all-ones value. After that, every further event that reaches it produces a one-cycle interrupt pulse, provided that counter's mask bit is set. The CRC counter works only in extended-superframe mode, and both framing-related counters stop while sync is lost.

Top module: `t1_perf_err_bank`

## Requirements
- R1: Valid zero bits (`line_bit_vld`=1, `line_bit`=0) build a run. When the run reaches 8 zeros with `b8zs_en`=1, or 16 zeros with `b8zs_en`=0, one excessive-zero event fires and the run restarts from zero. A valid one bit clears the run. Cycles with `line_bit_vld`=0 leave the run unchanged.
- R2: `viol_cnt` grows by one in each cycle that has `bpv_evt` or an excessive-zero event, or both (both in one cycle count once). It counts whatever the state of `los`, and it stops at 65535.
- R3: A write to address 0 stages `wr_data` as a high byte and leaves `viol_cnt` unchanged. A write to address 1 sets `viol_cnt` to {staged byte, `wr_data`} on the next clock.
- R4: With `esf_mode`=1, `crc_cnt` grows by one per `crc_err_evt` and stops at 255, and address 2 presets it. With `esf_mode`=0, `crc_cnt` is forced to zero, and CRC events and writes to address 2 have no effect.
- R5: `oof_cnt` grows by one per `oof_evt` and stops at 255. Address 3 presets it.
- R6: While `los`=1, `crc_err_evt` and `oof_evt` have no effect on their counters.
- R7: When a write loads a counter in the same cycle as an event aimed at that counter, the written value is kept, and the event is dropped without raising an interrupt.
- R8: An event that reaches a counter already at its maximum, with no write to that counter in the same cycle and that counter's mask bit set, drives `irq` high for exactly the next cycle. The mask bits are: bit 0 for the violation counter, bit 1 for the CRC counter, bit 2 for the OOF counter. `irq` is the OR of the three masked sources.
- R9: `rd_data` shows, without a clock delay, the value at `rd_addr`: 0 gives the high byte of `viol_cnt`, 1 its low byte, 2 `crc_cnt`, 3 `oof_cnt`.
- R10: After reset, all counts, the staged byte and the zero run are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_bit_vld | input | 1 | Qualifies `line_bit` for this cycle |
| line_bit | input | 1 | Decoded line data bit |
| bpv_evt | input | 1 | Bipolar violation strobe |
| crc_err_evt | input | 1 | CRC-6 word error strobe |
| oof_evt | input | 1 | Out-of-frame event strobe |
| b8zs_en | input | 1 | 1: 8-zero threshold, 0: 16-zero threshold |
| esf_mode | input | 1 | 1: extended superframe, 0: superframe |
| los | input | 1 | Loss of sync |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| irq_mask | input | 3 | Per-counter enable for the saturation interrupt |
| viol_cnt | output | 16 | Violation plus excessive-zero count |
| crc_cnt | output | 8 | CRC word error count |
| oof_cnt | output | 8 | Out-of-frame count |
| irq | output | 1 | Post-saturation event pulse |

## Verification
Most internal state in this block is visible at the ports one clock after it changes, because every count is an output. A wrong count, a lost increment or a count that wraps therefore shows up at the next edge. Two pieces of state are hidden: the zero-run length and the staged high byte. A wrong run length shows up only when the 8th or 16th zero fails to add to `viol_cnt`, or when it adds at the wrong bit, so runs are driven right up to each threshold, one bit short of it and across a threshold change. A corrupted staged byte appears only on the next low-byte preset, so every high-byte write is followed by a preset and a read.

// File: rtl/t1pm_pkg.sv
`timescale 1ns/1ps
package t1pm_pkg;
  localparam int BYTE_W = 8;
  localparam int N_SRC  = 3;

  typedef enum logic [1:0] {
    ADR_VIOL_HI = 2'd0,
    ADR_VIOL_LO = 2'd1,
    ADR_CRC     = 2'd2,
    ADR_OOF     = 2'd3
  } t1pm_addr_e;

  localparam int SRC_VIOL = 0;
  localparam int SRC_CRC  = 1;
  localparam int SRC_OOF  = 2;
endpackage

// File: rtl/t1pm_zero_run.sv
`timescale 1ns/1ps
module t1pm_zero_run #(
  parameter int SHORT_RUN = 8,
  parameter int LONG_RUN  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_val,
  input  logic short_sel,
  output logic exz_evt
);
  localparam int RW = $clog2(LONG_RUN);

  logic [RW-1:0] run_q, run_nxt, lim;
  logic          run_upd;

  always_comb begin
    lim     = short_sel ? RW'(SHORT_RUN - 1) : RW'(LONG_RUN - 1);
    exz_evt = bit_vld & ~bit_val & (run_q >= lim);
    run_upd = bit_vld;
    if (bit_val || exz_evt) run_nxt = '0;
    else                    run_nxt = run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (run_upd) run_q <= run_nxt;
  end
endmodule

// File: rtl/t1pm_sat_cnt.sv
`timescale 1ns/1ps
module t1pm_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         ev,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         sat_ev
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_nxt;
  logic         hit, at_max, upd;

  always_comb begin
    at_max  = (cnt_q == MAXV);
    hit     = ev & en & ~ld & ~clr;
    sat_ev  = hit & at_max;
    upd     = clr | ld | (hit & ~at_max);
    if (clr)     cnt_nxt = '0;
    else if (ld) cnt_nxt = ld_val;
    else         cnt_nxt = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/t1_perf_err_bank.sv
`timescale 1ns/1ps
module t1_perf_err_bank
  import t1pm_pkg::*;
#(
  parameter int SHORT_RUN = 8,
  parameter int LONG_RUN  = 16,
  parameter int CNT_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_bit_vld,
  input  logic                    line_bit,
  input  logic                    bpv_evt,
  input  logic                    crc_err_evt,
  input  logic                    oof_evt,
  input  logic                    b8zs_en,
  input  logic                    esf_mode,
  input  logic                    los,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [1:0]              rd_addr,
  output logic [BYTE_W-1:0]       rd_data,
  input  logic [N_SRC-1:0]        irq_mask,
  output logic [CNT_BYTES*BYTE_W-1:0] viol_cnt,
  output logic [BYTE_W-1:0]       crc_cnt,
  output logic [BYTE_W-1:0]       oof_cnt,
  output logic                    irq
);
  localparam int VW = CNT_BYTES * BYTE_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  // write decode
  logic wr_hi, wr_lo, wr_crc, wr_oof;
  always_comb begin
    wr_hi  = wr_en & (wr_addr == ADR_VIOL_HI);
    wr_lo  = wr_en & (wr_addr == ADR_VIOL_LO);
    wr_crc = wr_en & (wr_addr == ADR_CRC) & esf_mode;
    wr_oof = wr_en & (wr_addr == ADR_OOF);
  end

  // staged high part of the wide preset
  logic [VW-BYTE_W-1:0] hold_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  hold_q <= '0;
    else if (wr_hi)  hold_q <= {hold_q[VW-BYTE_W-1:0], wr_data} [VW-BYTE_W-1:0];
  end

  // excessive-zero detector
  logic exz_evt;
  t1pm_zero_run #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_zrun (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bit_vld   (line_bit_vld),
    .bit_val   (line_bit),
    .short_sel (b8zs_en),
    .exz_evt   (exz_evt)
  );

  logic [N_SRC-1:0] sat_ev;

  t1pm_sat_cnt #(.W(VW)) u_viol (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr    (1'b0),
    .ld     (wr_lo),
    .ld_val ({hold_q, wr_data}),
    .ev     (bpv_evt | exz_evt),
    .en     (1'b1),
    .cnt    (viol_cnt),
    .sat_ev (sat_ev[SRC_VIOL])
  );

  t1pm_sat_cnt #(.W(BYTE_W)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr    (~esf_mode),
    .ld     (wr_crc),
    .ld_val (wr_data),
    .ev     (crc_err_evt),
    .en     (~los),
    .cnt    (crc_cnt),
    .sat_ev (sat_ev[SRC_CRC])
  );

  t1pm_sat_cnt #(.W(BYTE_W)) u_oof (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr    (1'b0),
    .ld     (wr_oof),
    .ld_val (wr_data),
    .ev     (oof_evt),
    .en     (~los),
    .cnt    (oof_cnt),
    .sat_ev (sat_ev[SRC_OOF])
  );

  // interrupt pulse
  logic irq_nxt, irq_q;
  always_comb irq_nxt = |(sat_ev & irq_mask);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) irq_q <= 1'b0;
    else            irq_q <= irq_nxt;
  end
  assign irq = irq_q;

  // read mux
  always_comb begin
    unique case (rd_addr)
      ADR_VIOL_HI: rd_data = viol_cnt[VW-1 -: BYTE_W];
      ADR_VIOL_LO: rd_data = viol_cnt[BYTE_W-1:0];
      ADR_CRC:     rd_data = crc_cnt;
      default:     rd_data = oof_cnt;
    endcase
  end
endmodule

// File: rtl/t1_perf_err_bank_chk.sv
`timescale 1ns/1ps
module t1_perf_err_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        line_bit_vld,
  input logic        bpv_evt,
  input logic        crc_err_evt,
  input logic        oof_evt,
  input logic        esf_mode,
  input logic        los,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [2:0]  irq_mask,
  input logic [15:0] viol_cnt,
  input logic [7:0]  crc_cnt,
  input logic [7:0]  oof_cnt,
  input logic        irq
);
  p_viol_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_cnt == 16'hFFFF && !(wr_en && wr_addr == 2'd1)) |=> (viol_cnt == 16'hFFFF));

  p_hi_write_stages_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && !bpv_evt && !line_bit_vld) |=> $stable(viol_cnt));

  p_crc_zero_sf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!esf_mode) |=> (crc_cnt == 8'd0));

  p_oof_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oof_cnt == 8'hFF && !(wr_en && wr_addr == 2'd3)) |=> (oof_cnt == 8'hFF));

  p_los_holds_oof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !(wr_en && wr_addr == 2'd3)) |=> $stable(oof_cnt));

  p_irq_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bpv_evt && !crc_err_evt && !oof_evt && !line_bit_vld) |=> !irq);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 3'b000) |=> !irq);
endmodule

bind t1_perf_err_bank t1_perf_err_bank_chk chk_i (.*);

// File: tb/t1_perf_err_bank_tb_top.sv
`timescale 1ns/1ps
module t1_perf_err_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_bit_vld = 1'b0, line_bit = 1'b0;
  logic        bpv_evt = 1'b0, crc_err_evt = 1'b0, oof_evt = 1'b0;
  logic        b8zs_en = 1'b1, esf_mode = 1'b1, los = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0, rd_data;
  logic [2:0]  irq_mask = 3'b000;
  logic [15:0] viol_cnt;
  logic [7:0]  crc_cnt, oof_cnt;
  logic        irq;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  // reference model state
  int m_viol = 0, m_crc = 0, m_oof = 0, m_run = 0, m_hold = 0;
  bit m_irq = 0;

  always #5 clk = ~clk;

  t1_perf_err_bank dut_i (.*);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    int rd_exp;
    chk("R2 viol_cnt", viol_cnt, m_viol);
    chk("R4 crc_cnt", crc_cnt, m_crc);
    chk("R5 oof_cnt", oof_cnt, m_oof);
    chk("R8 irq", irq, m_irq);
    case (rd_addr)
      2'd0: rd_exp = m_viol / 256;
      2'd1: rd_exp = m_viol % 256;
      2'd2: rd_exp = m_crc;
      default: rd_exp = m_oof;
    endcase
    chk("R9 rd_data", rd_data, rd_exp);
  endtask

  // one clock: model next state, edge, compare
  task automatic step();
    int thr;
    bit exz, irqn;
    rd_addr = 2'(cyc);
    thr = b8zs_en ? 8 : 16;
    exz = 0; irqn = 0;
    if (line_bit_vld) begin
      if (!line_bit) begin
        if (m_run + 1 >= thr) begin exz = 1; m_run = 0; end
        else m_run++;
      end else m_run = 0;
    end
    if (wr_en && wr_addr == 2'd1) m_viol = m_hold * 256 + wr_data;
    else if (bpv_evt || exz) begin
      if (m_viol == 65535) irqn |= irq_mask[0]; else m_viol++;
    end
    if (wr_en && wr_addr == 2'd0) m_hold = wr_data;
    if (!esf_mode) m_crc = 0;
    else if (wr_en && wr_addr == 2'd2) m_crc = wr_data;
    else if (crc_err_evt && !los) begin
      if (m_crc == 255) irqn |= irq_mask[1]; else m_crc++;
    end
    if (wr_en && wr_addr == 2'd3) m_oof = wr_data;
    else if (oof_evt && !los) begin
      if (m_oof == 255) irqn |= irq_mask[2]; else m_oof++;
    end
    m_irq = irqn;
    @(posedge clk); #1;
    cyc++;
    compare_all();
    line_bit_vld = 0; bpv_evt = 0; crc_err_evt = 0; oof_evt = 0; wr_en = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic zeros(int n);
    for (int i = 0; i < n; i++) begin line_bit_vld = 1; line_bit = 0; step(); end
  endtask
  task automatic one_bit();
    line_bit_vld = 1; line_bit = 1; step();
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask
  task automatic pulse_viol(int n);
    for (int i = 0; i < n; i++) begin bpv_evt = 1; step(); end
  endtask
  task automatic pulse_crc(int n);
    for (int i = 0; i < n; i++) begin crc_err_evt = 1; step(); end
  endtask
  task automatic pulse_oof(int n);
    for (int i = 0; i < n; i++) begin oof_evt = 1; step(); end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 viol_cnt", viol_cnt, 0);
    chk("R10 crc_cnt", crc_cnt, 0);
    chk("R10 oof_cnt", oof_cnt, 0);
    chk("R10 irq", irq, 0);
    rst_n = 1;
    idle(4);

    // R1: 8-zero threshold, one bit restarts, bits without valid ignored
    b8zs_en = 1;
    zeros(7); one_bit(); zeros(7);
    line_bit = 0; step();            // not valid: run stays at 7
    zeros(1);                        // 8th zero -> event
    chk("R1 exz at 8", viol_cnt, 1);
    zeros(16);
    chk("R1 two more runs", viol_cnt, 3);
    // R1: 16-zero threshold
    b8zs_en = 0;
    zeros(15); one_bit(); zeros(16);
    chk("R1 exz at 16", viol_cnt, 4);
    // R2: counts during loss of sync, coincident sources count once
    los = 1; pulse_viol(3);
    b8zs_en = 1; zeros(7); bpv_evt = 1; zeros(1);
    chk("R2 coincident once", viol_cnt, 8);
    los = 0;

    // R3 preset, then saturate (R8 with mask)
    wr(2'd0, 8'hFF);
    chk("R3 hi write staged only", viol_cnt, 8);
    wr(2'd1, 8'hFD);
    chk("R3 preset loaded", viol_cnt, 16'hFFFD);
    irq_mask = 3'b001;
    pulse_viol(3);
    chk("R8 viol saturation irq", irq, 1);
    step();
    chk("R8 irq one cycle", irq, 0);
    irq_mask = 3'b000; pulse_viol(2);
    // R7: write and event together
    irq_mask = 3'b111;
    wr(2'd0, 8'h00);
    bpv_evt = 1; wr(2'd1, 8'h05);
    chk("R7 write wins", viol_cnt, 5);
    chk("R7 no irq", irq, 0);

    // R4: superframe mode holds CRC counter at zero
    esf_mode = 0;
    pulse_crc(3); wr(2'd2, 8'h40);
    chk("R4 sf zero", crc_cnt, 0);
    esf_mode = 1;
    wr(2'd2, 8'hFD); pulse_crc(3);
    chk("R8 crc saturated", crc_cnt, 255);
    los = 1; pulse_crc(2); pulse_oof(2);   // R6
    chk("R6 oof held", oof_cnt, 0);
    los = 0;
    // R5 oof preset and saturation
    wr(2'd3, 8'hFE); pulse_oof(3);
    chk("R5 oof saturated", oof_cnt, 255);
    oof_evt = 1; wr(2'd3, 8'h10);
    chk("R7 oof write wins", oof_cnt, 16);

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      line_bit_vld = r[0]; line_bit = r[1] & r[2];
      bpv_evt = (r[7:3] == 0); crc_err_evt = r[8] & r[9];
      oof_evt = r[10] & r[11];
      if (r[15:12] == 0) b8zs_en = r[16];
      if (r[20:17] == 0) esf_mode = r[21];
      if (r[24:22] == 0) los = r[25];
      irq_mask = 3'(r[28:26] | 3'(r[31]));
      wr_en = (r[31:29] == 0) && (r[5:4] != 0);
      wr_addr = 2'($urandom); wr_data = 8'($urandom) | 8'hF0;
      step();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule